// File: doc/BRIEF.md
# TDM Test-Pattern Serial Transmitter

This block drives a four-slot, 32-bit-per-slot serial audio stream whose content describes itself. Every slot word carries a fixed marker byte, the index of the frame it belongs to and the number of its slot. A receiver that captures the stream can therefore tell from any single word where in the frame it has locked on. It is meant for bring-up benches that study how a serial audio receiver aligns to a stream.

The frame-sync output can be held low for a programmable number of leading frames. During those frames data is shifted out as usual, but nothing marks the frame boundary. A receiver under test therefore has to pick some alignment of its own, and the point where it re-aligns once sync pulses appear can be seen in its captured words. One bit goes out per bit-clock enable pulse. The frame-sync output pulses high on the first bit of slot 1. After a programmable number of frames the block stops, drives its outputs low and raises a done flag until it is started again.

Top module: `tdm_pattern_tx`

## Requirements
- R1: While reset is high, and after it until the first start, the data, frame-sync and done outputs are all low.
- R2: A start pulse while idle or done begins a run at frame 0, slot 1, bit 31. Data stays low until the first bit-clock enable pulse after the start.
- R3: Each slot word has bits 31..24 equal to 0xAA, bits 23..8 equal to the frame index modulo 65536 (the first frame is 0), and bits 7..0 equal to the slot number, 1 to 4.
- R4: Words are sent MSB first, one bit per bit-clock enable pulse. The outputs change only at a clock edge where the enable is sampled high and hold their value in between.
- R5: A frame is 128 bits made of slots 1, 2, 3 and 4 in that order. All four slots of a frame carry the same frame index, which rises by one from each frame to the next.
- R6: For frames with an index below the sync start parameter, frame-sync stays low for all 128 bits.
- R7: From the sync start frame onward, frame-sync is high exactly during the first bit of slot 1 of each frame and low for its other 127 bits.
- R8: Once the last bit of the final frame has been sent, the next enable pulse drives data and frame-sync low and raises done. These values hold until a start pulse arrives, whatever the enable does.
- R9: A start pulse during a run is ignored, and the stream goes on with no skipped or repeated bit.
- R10: A start pulse while done is high clears done on the next clock edge and resends the stream from frame 0, slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bclk_en | input | 1 | Bit-clock enable; one pulse shifts out one bit |
| start | input | 1 | Begins a run when the block is idle or done |
| sdata | output | 1 | Serial data, MSB first |
| lrck | output | 1 | Frame-sync pulse on the first bit of slot 1 |
| done | output | 1 | High after the final frame until the next start |

## Verification
The bench decodes every bit of a full run into words. A design that swapped fields, numbered slots from 0 or advanced the frame index per slot would then fail on specific words. It checks frame-sync bit by bit on both sides of the sync start frame, which exposes a pulse one frame early, one bit late or repeated on every slot. A start pulse is injected mid-frame, because a design that restarts on it would resend frame 0 where frame 2 is due. The bench also looks at the cycle boundary after the last bit and at a restart from done: a design that signals done one bit early, leaves the last data bit on the line, or carries a stale frame index into the second run fails there.

// File: rtl/tdm_pat_pkg.sv
package tdm_pat_pkg;

    localparam int WORD_W  = 32;
    localparam int MARK_W  = 8;
    localparam int CNT_W   = 16;
    localparam int ID_W    = 8;
    localparam logic [MARK_W-1:0] MARKER = 8'hAA;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic [MARK_W-1:0] mark;
        logic [CNT_W-1:0]  cnt;
        logic [ID_W-1:0]   id;
    } slot_word_t;

    typedef struct packed {
        logic sd;
        logic fs;
    } line_t;

    function automatic slot_word_t build_word(input logic [CNT_W-1:0] cnt,
                                              input logic [ID_W-1:0]  id);
        slot_word_t w;
        w.mark = MARKER;
        w.cnt  = cnt;
        w.id   = id;
        return w;
    endfunction

endpackage

// File: rtl/tdm_bit_pos.sv
module tdm_bit_pos #(
    parameter int SLOT_BITS = 32,
    parameter int SLOTS     = 4,
    localparam int BW = $clog2(SLOT_BITS),
    localparam int SW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          adv,
    output logic [BW-1:0] bit_idx,
    output logic [SW-1:0] slot_idx,
    output logic          frame_end
);

    localparam logic [BW-1:0] BIT_LAST  = BW'(SLOT_BITS - 1);
    localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);

    logic slot_end;

    assign slot_end  = adv && (bit_idx == BIT_LAST);
    assign frame_end = slot_end && (slot_idx == SLOT_LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            bit_idx  <= '0;
            slot_idx <= '0;
        end else if (adv) begin
            if (bit_idx == BIT_LAST) begin
                bit_idx  <= '0;
                slot_idx <= (slot_idx == SLOT_LAST) ? '0 : slot_idx + 1'b1;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (bit_idx == '0) && (slot_idx == '0)); // R5

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (slot_end && !frame_end && !clear) |=> (slot_idx == $past(slot_idx) + 1'b1)); // R5

endmodule

// File: rtl/tdm_frame_seq.sv
module tdm_frame_seq
    import tdm_pat_pkg::*;
#(
    parameter int NUM_FRAMES = 1000,
    parameter int FW         = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          bclk_en,
    input  logic          frame_end,
    output tx_state_e     state,
    output logic [FW-1:0] frame_idx,
    output logic          accept,
    output logic          send,
    output logic          finish
);

    localparam logic [FW-1:0] LAST = FW'(NUM_FRAMES);

    logic tick;

    assign tick   = bclk_en && (state == ST_RUN);
    assign accept = start && (state != ST_RUN);
    assign send   = tick && (frame_idx != LAST);
    assign finish = tick && (frame_idx == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            frame_idx <= '0;
        end else if (accept) begin
            state     <= ST_RUN;
            frame_idx <= '0;
        end else if (finish) begin
            state <= ST_DONE;
        end else if (frame_end) begin
            frame_idx <= frame_idx + 1'b1;
        end
    end

    AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (rst)
        frame_idx <= LAST); // R8

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && start && !bclk_en) |=> (state == ST_RUN) && $stable(frame_idx)); // R9

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE && !start) |=> (state == ST_DONE)); // R8

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        accept |=> (state == ST_RUN) && (frame_idx == '0)); // R10

endmodule

// File: rtl/tdm_word_gen.sv
module tdm_word_gen
    import tdm_pat_pkg::*;
#(
    parameter int FW             = 10,
    parameter int SW             = 2,
    parameter int BW             = 5,
    parameter int FS_FIRST_FRAME = 500
) (
    input  logic [FW-1:0] frame_idx,
    input  logic [SW-1:0] slot_idx,
    input  logic [BW-1:0] bit_idx,
    output line_t         nxt
);

    localparam logic [FW-1:0] FS_FIRST = FW'(FS_FIRST_FRAME);

    slot_word_t            word;
    logic [WORD_W-1:0]     word_bits;
    logic [CNT_W-1:0]      cnt_field;
    logic [ID_W-1:0]       id_field;

    always_comb begin
        cnt_field = CNT_W'(frame_idx);
        id_field  = ID_W'(slot_idx) + 1'b1;
        word      = build_word(cnt_field, id_field);
        word_bits = word;
        nxt.sd    = word_bits[(WORD_W - 1) - int'(bit_idx)];
        nxt.fs    = (frame_idx >= FS_FIRST) && (slot_idx == '0) && (bit_idx == '0);
    end

endmodule

// File: rtl/tdm_pattern_tx.sv
module tdm_pattern_tx
    import tdm_pat_pkg::*;
#(
    parameter int NUM_FRAMES     = 1000,
    parameter int FS_FIRST_FRAME = 500,
    parameter int SLOTS          = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk_en,
    input  logic start,
    output logic sdata,
    output logic lrck,
    output logic done
);

    localparam int FMAX = (NUM_FRAMES > FS_FIRST_FRAME) ? NUM_FRAMES : FS_FIRST_FRAME;
    localparam int FW   = $clog2(FMAX + 1);
    localparam int BW   = $clog2(WORD_W);
    localparam int SW   = $clog2(SLOTS);

    tx_state_e     state;
    logic [FW-1:0] frame_idx;
    logic [BW-1:0] bit_idx;
    logic [SW-1:0] slot_idx;
    logic          accept;
    logic          send;
    logic          finish;
    logic          frame_end;
    line_t         nxt;
    line_t         line_q;

    tdm_frame_seq #(
        .NUM_FRAMES (NUM_FRAMES),
        .FW         (FW)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .bclk_en   (bclk_en),
        .frame_end (frame_end),
        .state     (state),
        .frame_idx (frame_idx),
        .accept    (accept),
        .send      (send),
        .finish    (finish)
    );

    tdm_bit_pos #(
        .SLOT_BITS (WORD_W),
        .SLOTS     (SLOTS)
    ) u_pos (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .adv       (send),
        .bit_idx   (bit_idx),
        .slot_idx  (slot_idx),
        .frame_end (frame_end)
    );

    tdm_word_gen #(
        .FW             (FW),
        .SW             (SW),
        .BW             (BW),
        .FS_FIRST_FRAME (FS_FIRST_FRAME)
    ) u_word (
        .frame_idx (frame_idx),
        .slot_idx  (slot_idx),
        .bit_idx   (bit_idx),
        .nxt       (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst || accept || finish) begin
            line_q <= '0;
        end else if (send) begin
            line_q <= nxt;
        end
    end

    assign sdata = line_q.sd;
    assign lrck  = line_q.fs;
    assign done  = (state == ST_DONE);

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (!sdata && !lrck)); // R8

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
        !$past(bclk_en) |-> ($stable(sdata) && $stable(lrck))); // R4

    AST_NO_EARLY_FS: assert property (@(posedge clk) disable iff (rst)
        lrck |-> (frame_idx >= FW'(FS_FIRST_FRAME))); // R6

    AST_FS_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (lrck && bclk_en && !start) |=> !lrck); // R7

endmodule

// File: tb/tdm_pattern_tx_tb.sv
module tdm_pattern_tx_tb;

    localparam int NF  = 6;
    localparam int FSF = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bclk_en = 1'b0;
    logic start = 1'b0;
    logic sdata, lrck, done;

    int checks = 0;
    int fails  = 0;
    int hold_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tdm_pattern_tx #(
        .NUM_FRAMES     (NF),
        .FS_FIRST_FRAME (FSF),
        .SLOTS          (4)
    ) u_dut (
        .clk     (clk),
        .rst     (rst),
        .bclk_en (bclk_en),
        .start   (start),
        .sdata   (sdata),
        .lrck    (lrck),
        .done    (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int f, input int s);
        return {8'hAA, 16'(f), 8'(s + 1)};
    endfunction

    // one bit period: enable pulse, sample, then watch the line hold (R4)
    task automatic one_bit(input bit poke, output logic sd, output logic fs);
        @(negedge clk) bclk_en = 1'b1;
        @(negedge clk) bclk_en = 1'b0;
        sd = sdata;
        fs = lrck;
        for (int k = 0; k < 3; k++) begin
            start = (poke && k == 0);
            @(negedge clk);
            if (sdata !== sd || lrck !== fs) hold_err++;
        end
        start = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check(sdata === 1'b0 && lrck === 1'b0 && done === 1'b0, "R1", "outputs in reset",
              {sdata, lrck, done}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(sdata === 1'b0 && lrck === 1'b0 && done === 1'b0, "R1", "outputs after reset",
              {sdata, lrck, done}, 0);
    endtask

    // full run, with a start pulse injected mid-frame 2 (R9)
    task automatic t_stream();
        logic sd, fs;
        logic [31:0] w;
        int fs_err, r9_err;
        pulse_start();
        @(negedge clk);
        check(sdata === 1'b0 && done === 1'b0, "R2", "line before first bit", {sdata, done}, 0);
        r9_err = 0;
        for (int f = 0; f < NF; f++) begin
            fs_err = 0;
            for (int s = 0; s < 4; s++) begin
                w = '0;
                for (int b = 0; b < 32; b++) begin
                    one_bit(f == 2 && s == 1 && b == 5, sd, fs);
                    w = {w[30:0], sd};
                    if (fs !== (f >= FSF && s == 0 && b == 0)) fs_err++;
                end
                if (f == 2 && w !== exp_word(f, s)) r9_err++;
                check(w === exp_word(f, s), (f == 0 && s == 0) ? "R2" : "R3/R5",
                      $sformatf("frame %0d slot %0d word", f, s + 1), w, exp_word(f, s));
            end
            check(fs_err == 0, (f < FSF) ? "R6" : "R7",
                  $sformatf("frame %0d lrck bit errors", f), fs_err, 0);
        end
        check(r9_err == 0, "R9", "words after mid-run start", r9_err, 0);
        check(hold_err == 0, "R4", "line changed between enables", hold_err, 0);
    endtask

    task automatic t_done();
        logic sd, fs;
        int bad;
        check(done === 1'b0, "R8", "done before closing pulse", done, 0);
        one_bit(1'b0, sd, fs);
        check(done === 1'b1 && sd === 1'b0 && fs === 1'b0, "R8", "closing pulse",
              {done, sd, fs}, 3'b100);
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            one_bit(1'b0, sd, fs);
            if (done !== 1'b1 || sd !== 1'b0 || fs !== 1'b0) bad++;
        end
        check(bad == 0, "R8", "line quiet while done", bad, 0);
    endtask

    task automatic t_restart();
        logic sd, fs;
        logic [31:0] w;
        pulse_start();
        check(done === 1'b0, "R10", "done cleared by start", done, 0);
        for (int s = 0; s < 2; s++) begin
            w = '0;
            for (int b = 0; b < 32; b++) begin
                one_bit(1'b0, sd, fs);
                w = {w[30:0], sd};
            end
            check(w === exp_word(0, s), "R10", $sformatf("restart slot %0d word", s + 1),
                  w, exp_word(0, s));
        end
    endtask

    initial begin
        t_reset();
        t_stream();
        t_done();
        t_restart();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule